// File: doc/BRIEF.md
# Register-Mapped Pseudo-Random Word Source

This block places a pseudo-random word generator behind a small 32-bit register bus. A host selects the block with a chip select and presents a 4-bit byte address. It writes with a write enable, or it reads by pulsing a read strobe while the write enable is low. The 16-byte window has three 32-bit registers. The control word at offset 0x0 is free-form storage. The status word at offset 0x4 mixes a 20-bit writable field with read-only upper bits. The data word at offset 0x8 hands out a new random word on every read.

The generator is a 32-bit xorshift register. It loads a nonzero seed at reset and steps once for each read of the data offset, and at no other time. The value the generator steps to is the word that read returns. Read data is registered and appears on the read bus one clock after the strobe. It then holds until the next read. Only the aligned offsets 0x0, 0x4 and 0x8 are mapped. Every other byte address reads as zero and ignores writes.

Top module: `rng_periph`

## Requirements
- R1: After reset the control and status registers are zero and the read bus is zero. A control read then returns 0x0000_0000 and a status read returns 0x0100_0000.
- R2: A write to offset 0x0 stores all 32 bits, and a read of offset 0x0 returns the last value written.
- R3: A write to offset 0x4 changes only stored status bits [19:0]. Stored bits [31:20] keep their value, which is zero because no write can reach them.
- R4: Every read of offset 0x4 returns bit 24 set, ORed with the stored status value.
- R5: A read of offset 0x8 steps the generator once, x ^= x<<13; x ^= x>>17; x ^= x<<5, starting from the seed 0x2545_F491, and returns the stepped value. No other access steps the generator.
- R6: A data word is never zero, and two back-to-back data reads return different words.
- R7: A write to offset 0x8 has no effect. It does not change the generator sequence or any register.
- R8: A read of any offset other than 0x0, 0x4 or 0x8 returns zero. This includes the unaligned offsets and 0xC. A write to such an offset is ignored.
- R9: Read data appears on the read bus on the clock edge that samples the read strobe. It stays unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable (write when cs is high) |
| rdStb | input | 1 | Read strobe (read when cs is high and we is low) |
| addr | input | 4 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest condition to reach is a data read held for two consecutive clocks. Here the generator must step on both edges, and the second word must differ from the first. The bench holds the strobe high across two edges and compares both words with its own model of the recurrence. A second hard case is a write to the data offset or a read of another register between data reads. Either one would silently shift the whole sequence if it stepped the generator. The bench therefore mixes these accesses between data reads and keeps checking every later word against the model.

// File: rtl/rng_periph_pkg.sv
package rng_periph_pkg;

  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int STAT_WR_W  = 20;
  localparam int AVAIL_BIT  = 24;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h8;

  typedef struct packed {
    logic ctrlWe;
    logic statWe;
    logic rdCtrl;
    logic rdStat;
    logic rdData;
    logic rdAny;
  } strobes_t;

  // one step of the 32-bit xorshift recurrence; nonzero in gives nonzero out
  function automatic logic [DATA_W-1:0] xsStep(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

endpackage

// File: rtl/rng_periph_ctrl.sv
module rng_periph_ctrl
  import rng_periph_pkg::*;
(
  input  logic              cs,
  input  logic              we,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);

  logic isCtrl, isStat, isData, doWr, doRd;

  always_comb begin
    isCtrl = (addr == OFS_CTRL);
    isStat = (addr == OFS_STAT);
    isData = (addr == OFS_DATA);
    doWr   = cs && we;
    doRd   = cs && !we && rdStb;

    stb.ctrlWe = doWr && isCtrl;
    stb.statWe = doWr && isStat;
    stb.rdCtrl = doRd && isCtrl;
    stb.rdStat = doRd && isStat;
    stb.rdData = doRd && isData;
    stb.rdAny  = doRd;
  end

endmodule

// File: rtl/rng_periph_dp.sv
module rng_periph_dp
  import rng_periph_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEED = 32'h2545_F491
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] AVAIL_MASK = DATA_W'(1) << AVAIL_BIT;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] genState;
  logic [DATA_W-1:0] genNext;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    genNext = xsStep(genState);
    if (stb.rdCtrl)      rdMux = ctrlReg;
    else if (stb.rdStat) rdMux = statReg | AVAIL_MASK;
    else if (stb.rdData) rdMux = genNext;
    else                 rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      statReg  <= '0;
      genState <= SEED;
      rdata    <= '0;
    end else begin
      if (stb.ctrlWe) ctrlReg <= wdata;
      if (stb.statWe) statReg[STAT_WR_W-1:0] <= wdata[STAT_WR_W-1:0];
      if (stb.rdData) genState <= genNext;
      if (stb.rdAny)  rdata <= rdMux;
    end
  end

endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_periph_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h2545_F491
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cs,
  input  logic        we,
  input  logic        rdStb,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  strobes_t stb;

  rng_periph_ctrl u_ctrl (
    .cs    (cs),
    .we    (we),
    .rdStb (rdStb),
    .addr  (addr),
    .stb   (stb)
  );

  rng_periph_dp #(.SEED(SEED)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (wdata),
    .rdata (rdata)
  );

endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cs,
  input logic        we,
  input logic        rdStb,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata
);

  logic anyRd, statRd, dataRd, badRd;
  logic wdataSeen;

  assign anyRd  = cs && !we && rdStb;
  assign statRd = anyRd && (addr == 4'h4);
  assign dataRd = anyRd && (addr == 4'h8);
  assign badRd  = anyRd && (addr != 4'h0) && (addr != 4'h4) && (addr != 4'h8);
  assign wdataSeen = ^wdata;

  AST_STAT_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> rdata[24]) else $error("status read lost availability bit"); // R4

  AST_STAT_UPPER_RO: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> (rdata[31:25] == 7'd0 && rdata[23:20] == 4'd0)) else $error("status upper bits changed"); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    badRd |=> (rdata == 32'd0)) else $error("unmapped read nonzero"); // R8

  AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    dataRd |=> (rdata != 32'd0)) else $error("zero data word"); // R6

  AST_DATA_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd ##1 dataRd) |=> (rdata != $past(rdata))) else $error("repeated data word"); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!anyRd && !wdataSeen) || (!anyRd && wdataSeen) |=> $stable(rdata)) else $error("read bus moved without read"); // R9

endmodule

bind rng_periph rng_periph_chk u_chk (.*);

// File: tb/rng_periph_bench.sv
module rng_periph_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic        rdStb = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [31:0] model = 32'h2545_F491;

  always #5 clk = ~clk;

  rng_periph u_rng_periph (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we),
    .rdStb(rdStb), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] refStep(input logic [31:0] v);
    logic [31:0] a;
    a = v ^ (v << 13);
    a = a ^ (a >> 17);
    return a ^ (a << 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; rdStb = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; rdStb = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rdStb = 1'b0;
    d = rdata;
  endtask

  task automatic readData(input string req);
    logic [31:0] got;
    busRead(4'h8, got);
    model = refStep(model);
    check(req, got, model);
  endtask

  task automatic tReset();
    logic [31:0] got;
    check("R1 rdata after reset", rdata, 32'h0);
    busRead(4'h0, got);
    check("R1 ctrl reset", got, 32'h0);
    busRead(4'h4, got);
    check("R1 status reset", got, 32'h0100_0000);
  endtask

  task automatic tCtrl();
    logic [31:0] got;
    busWrite(4'h0, 32'hDEAD_BEEF);
    busRead(4'h0, got);
    check("R2 ctrl readback", got, 32'hDEAD_BEEF);
    busWrite(4'h0, 32'h1234_5678);
    busRead(4'h0, got);
    check("R2 ctrl overwrite", got, 32'h1234_5678);
  endtask

  task automatic tStatus();
    logic [31:0] got;
    busWrite(4'h4, 32'hFFFF_FFFF);
    busRead(4'h4, got);
    check("R3 status mask all-ones", got, 32'h010F_FFFF);
    busWrite(4'h4, 32'hABCD_E123);
    busRead(4'h4, got);
    check("R3 status mask pattern", got, 32'h010D_E123);
    busWrite(4'h4, 32'h0000_0000);
    busRead(4'h4, got);
    check("R4 status bit24 forced", got, 32'h0100_0000);
  endtask

  task automatic tDataSeq();
    for (int i = 0; i < 8; i++) readData("R5 data sequence");
  endtask

  task automatic tBackToBack();
    logic [31:0] w1, w2;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; rdStb = 1'b1; addr = 4'h8;
    @(negedge clk);
    w1 = rdata;
    @(negedge clk);
    cs = 1'b0; rdStb = 1'b0;
    w2 = rdata;
    model = refStep(model);
    check("R6 back-to-back first", w1, model);
    model = refStep(model);
    check("R6 back-to-back second", w2, model);
    nChecks++;
    if (w1 == w2 || w2 == 32'h0) begin
      nFails++;
      $display("FAIL R6 distinct nonzero: actual %08h expected not %08h", w2, w1);
    end
  endtask

  task automatic tDataWrite();
    logic [31:0] got;
    busWrite(4'h8, 32'h0000_0000);
    busWrite(4'h8, 32'hFFFF_FFFF);
    readData("R7 sequence after data write");
    busRead(4'h0, got);
    check("R7 ctrl untouched", got, 32'h1234_5678);
    busRead(4'h4, got);
    check("R7 status untouched", got, 32'h0100_0000);
  endtask

  task automatic tUnmapped();
    logic [31:0] got;
    busWrite(4'hC, 32'h5555_5555);
    busWrite(4'h1, 32'h7777_7777);
    busRead(4'hC, got);
    check("R8 read 0xC", got, 32'h0);
    busRead(4'h9, got);
    check("R8 read 0x9", got, 32'h0);
    busRead(4'h0, got);
    check("R8 ctrl unchanged", got, 32'h1234_5678);
    readData("R8 generator not stepped");
  endtask

  task automatic tHold();
    logic [31:0] held;
    readData("R9 read latency");
    held = rdata;
    repeat (3) @(negedge clk);
    check("R9 hold idle", rdata, held);
    busWrite(4'h0, 32'hCAFE_F00D);
    check("R9 hold across write", rdata, held);
    readData("R9 after hold");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCtrl();
    tStatus();
    tDataSeq();
    tBackToBack();
    tDataWrite();
    tUnmapped();
    tHold();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule